// File: doc/BRIEF.md
# Linked-Descriptor Memory-to-Stream Engine

This block moves bytes from memory to a byte-wide streaming consumer. The work is described by a chain of four-word descriptors stored in memory. Each descriptor gives the address of the next descriptor, the first byte of a buffer, a control word, and the address one past the buffer's last byte. The engine starts at a descriptor pointer and loads that descriptor, which sets its byte position to the buffer start. It then streams one byte per accepted handshake until the position equals the stop address. After that it reports completion, writes the descriptor back, and either follows the next pointer or halts at the end of the chain.

A completion is detected when the position equals the stored stop address. There is no length counter, so a descriptor whose start and stop addresses match moves no data but still completes normally. The memory side is a plain word port with a fixed one-cycle read latency. The interrupt side is a single pulse that a separate register block merges into its own status.

Top module: `desc_stream_dma`

## Requirements
- R1: After reset, `busy`, `eol_flag`, `st_valid`, `irq_pulse`, `mem_rd` and `mem_wr` are all low.
- R2: A `start` pulse taken while idle fetches the descriptor at `start_ptr` as four word reads at `start_ptr`, +4, +8 and +12, in that order. The words are next pointer, buffer start, control and stop address. Control bit 0 marks the end of the chain, bit 3 requests an end-of-packet marker and bit 4 requests an interrupt. All other control bits are ignored.
- R3: Each descriptor delivers the bytes from buffer start up to stop address minus one, in rising address order. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the word at a with its two low bits cleared.
- R4: A byte is presented with `st_valid` and stays unchanged, together with `st_last`, until `st_ready` is high at a clock edge. The position advances only on that handshake.
- R5: `st_last` is high on the last byte of a descriptor whose control bit 3 is set, and low on every other byte.
- R6: When a descriptor completes with control bit 4 set, `irq_pulse` is high for exactly one cycle. With bit 4 clear, no pulse is produced.
- R7: A completed descriptor's four words are written back unchanged to their own addresses, in the order +0, +4, +8, +12. This happens before any read of the following descriptor.
- R8: A completed descriptor with control bit 0 clear is followed by a fetch of the descriptor at its next pointer.
- R9: A completed descriptor with control bit 0 set makes `eol_flag` high and `busy` low. After that there is no stream or memory traffic until the next start.
- R10: A descriptor whose buffer start equals its stop address delivers no bytes, yet still pulses the interrupt (if bit 4 is set) and is written back.
- R11: A `start` pulse while `busy` is high has no effect on the running chain.
- R12: A `start` taken while `eol_flag` is high clears `eol_flag` and runs the new chain.
- R13: `mem_rd` and `mem_wr` are never high together, and every memory access is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a chain at `start_ptr` (taken only when idle) |
| start_ptr | input | ADDR_W | Address of the first descriptor |
| busy | output | 1 | Chain in progress |
| eol_flag | output | 1 | Last chain stopped at an end-of-chain descriptor |
| mem_rd | output | 1 | Word read request; data returns on the next cycle |
| mem_wr | output | 1 | Word write request |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, one cycle after `mem_rd` |
| st_valid | output | 1 | Stream byte valid |
| st_ready | input | 1 | Stream consumer ready |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | End-of-packet marker on the current byte |
| irq_pulse | output | 1 | One-cycle pulse on completion of an interrupting descriptor |

## Verification
The bench targets several edge cases, each with the failure it would expose:

- **Empty descriptor inside a chain:** an engine that tested for completion only after moving a byte would run through memory past the stop address.
- **Buffers starting and ending mid-word, under random ready stalls:** a wrong byte lane or an advance on an unaccepted byte shows up as a shifted, duplicated or missing byte.
- **Write-back order against the next fetch:** this catches an engine that advances before storing.
- **Start pulse during a run, and restart after the end of a chain:** these expose a restart that breaks the chain or an end flag that sticks.
- **Stray control bits:** these expose a decoder that reacts to bits it should ignore.

// File: rtl/dstr_pkg.sv
package dstr_pkg;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_FETCH  = 4'd1,
        S_FCAP   = 4'd2,
        S_CHECK  = 4'd3,
        S_BRD    = 4'd4,
        S_BCAP   = 4'd5,
        S_SEND   = 4'd6,
        S_FINISH = 4'd7,
        S_WB     = 4'd8
    } dstr_state_e;

    // word slots inside a descriptor
    localparam int DW_NEXT  = 0;
    localparam int DW_BUF   = 1;
    localparam int DW_CTL   = 2;
    localparam int DW_AFTER = 3;
    localparam int DESC_WORDS = 4;

    // control word bit positions
    localparam int CTL_END_BIT = 0;
    localparam int CTL_EOP_BIT = 3;
    localparam int CTL_IRQ_BIT = 4;

endpackage

// File: rtl/dstr_ctl_decode.sv
module dstr_ctl_decode
    import dstr_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] ctl,
    output logic              chain_end,
    output logic              pkt_end,
    output logic              irq_en
);
    logic ctl_unused;

    assign chain_end  = ctl[CTL_END_BIT];
    assign pkt_end    = ctl[CTL_EOP_BIT];
    assign irq_en     = ctl[CTL_IRQ_BIT];
    assign ctl_unused = ^ctl;
endmodule

// File: rtl/dstr_byte_pick.sv
module dstr_byte_pick #(
    parameter  int WORD_W = 32,
    localparam int LANES  = WORD_W / 8,
    localparam int SEL_W  = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output logic [7:0]        byte_o
);
    logic [LANES-1:0][7:0] lanes;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_o = lanes[sel];
endmodule

// File: rtl/desc_stream_dma.sv
module desc_stream_dma
    import dstr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_ptr,
    output logic              busy,
    output logic              eol_flag,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [7:0]        st_data,
    output logic              st_last,
    output logic              irq_pulse
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int LANE_W     = $clog2(WORD_BYTES);
    localparam int IDX_W      = $clog2(DESC_WORDS);

    typedef struct packed {
        dstr_state_e                        st;
        logic [IDX_W-1:0]                   idx;
        logic [ADDR_W-1:0]                  ptr;
        logic [ADDR_W-1:0]                  pos;
        logic [DESC_WORDS-1:0][WORD_W-1:0]  dw;
        logic [7:0]                         dat;
        logic                               eol;
    } dstr_reg_t;

    dstr_reg_t q, d;

    logic              chain_end, pkt_end, irq_en;
    logic [7:0]        picked;
    logic [ADDR_W-1:0] stop_addr;
    logic [ADDR_W-1:0] word_ofs;

    dstr_ctl_decode #(.WORD_W(WORD_W)) i_ctl_decode (
        .ctl       (q.dw[DW_CTL]),
        .chain_end (chain_end),
        .pkt_end   (pkt_end),
        .irq_en    (irq_en)
    );

    dstr_byte_pick #(.WORD_W(WORD_W)) i_byte_pick (
        .word   (mem_rdata),
        .sel    (q.pos[LANE_W-1:0]),
        .byte_o (picked)
    );

    assign stop_addr = q.dw[DW_AFTER][ADDR_W-1:0];
    assign word_ofs  = ADDR_W'({q.idx, {LANE_W{1'b0}}});

    always_comb begin
        d         = q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st  = S_FETCH;
                    d.ptr = start_ptr;
                    d.idx = '0;
                    d.eol = 1'b0;
                end
            end
            S_FETCH: begin
                mem_rd   = 1'b1;
                mem_addr = q.ptr + word_ofs;
                d.st     = S_FCAP;
            end
            S_FCAP: begin
                d.dw[q.idx] = mem_rdata;
                if (q.idx == IDX_W'(DW_BUF)) begin
                    d.pos = mem_rdata[ADDR_W-1:0];
                end
                d.idx = q.idx + 1'b1;
                d.st  = (q.idx == IDX_W'(DESC_WORDS - 1)) ? S_CHECK : S_FETCH;
            end
            S_CHECK: begin
                d.st = (q.pos == stop_addr) ? S_FINISH : S_BRD;
            end
            S_BRD: begin
                mem_rd   = 1'b1;
                mem_addr = {q.pos[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                d.st     = S_BCAP;
            end
            S_BCAP: begin
                d.dat = picked;
                d.st  = S_SEND;
            end
            S_SEND: begin
                if (st_ready) begin
                    d.pos = q.pos + 1'b1;
                    d.st  = S_CHECK;
                end
            end
            S_FINISH: begin
                d.idx = '0;
                d.st  = S_WB;
            end
            S_WB: begin
                mem_wr    = 1'b1;
                mem_addr  = q.ptr + word_ofs;
                mem_wdata = q.dw[q.idx];
                d.idx     = q.idx + 1'b1;
                if (q.idx == IDX_W'(DESC_WORDS - 1)) begin
                    if (chain_end) begin
                        d.eol = 1'b1;
                        d.st  = S_IDLE;
                    end else begin
                        d.ptr = q.dw[DW_NEXT][ADDR_W-1:0];
                        d.st  = S_FETCH;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != S_IDLE);
    assign eol_flag  = q.eol;
    assign st_valid  = (q.st == S_SEND);
    assign st_data   = q.dat;
    assign st_last   = (q.st == S_SEND) && pkt_end && ((q.pos + 1'b1) == stop_addr);
    assign irq_pulse = (q.st == S_FINISH) && irq_en;

endmodule

module desc_stream_dma_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_ptr,
    input logic              busy,
    input logic              eol_flag,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] mem_rdata,
    input logic              st_valid,
    input logic              st_ready,
    input logic [7:0]        st_data,
    input logic              st_last,
    input logic              irq_pulse
);
    localparam int LANE_W = $clog2(WORD_W / 8);

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R13

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[LANE_W-1:0] == '0)); // R13

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last))); // R4

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        st_last |-> st_valid); // R5

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R6

    AST_EOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        eol_flag |-> (!busy && !st_valid && !mem_rd && !mem_wr)); // R9

    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!irq_pulse && !st_valid)); // R1
endmodule

bind desc_stream_dma desc_stream_dma_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_desc_stream_dma.sv
`timescale 1ns/1ps
module test_desc_stream_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_ptr = 32'h0;
    logic        busy, eol_flag, mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        st_valid, st_last, irq_pulse;
    logic        st_ready = 1'b1;
    logic [7:0]  st_data;

    always #2 clk = ~clk;

    desc_stream_dma i_desc_stream_dma (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
        .busy(busy), .eol_flag(eol_flag), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
        .st_last(st_last), .irq_pulse(irq_pulse)
    );

    logic [31:0] mem [0:1023];
    always @(posedge clk) mem_rdata <= mem_rd ? mem[mem_addr[11:2]] : 32'h0;

    int n_chk = 0, n_fail = 0, cyc = 0, rdy_mode = 0;
    bit finished = 0;

    // expected
    logic [7:0]  exp_byte [0:511];
    bit          exp_last [0:511];
    logic [31:0] exp_wa [0:63];
    logic [31:0] exp_wd [0:63];
    logic [31:0] desc_at [0:15];
    int n_exp, n_expw, exp_irq, n_desc;
    // observed
    logic [7:0]  obs_byte [0:511];
    bit          obs_last [0:511];
    logic [31:0] obs_wa [0:63];
    logic [31:0] obs_wd [0:63];
    logic [31:0] obs_ra [0:1023];
    int n_obs, n_obsw, n_rd, obs_irq, fetch_k, ord_bad;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    // monitor: drive ready, then log what the next edge will take
    always @(negedge clk) begin
        st_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 5) < 3);
        if (rst_n) begin
            if (st_valid && st_ready && n_obs < 512) begin
                obs_byte[n_obs] = st_data;
                obs_last[n_obs] = st_last;
                n_obs++;
            end
            if (mem_wr && n_obsw < 64) begin
                obs_wa[n_obsw] = mem_addr;
                obs_wd[n_obsw] = mem_wdata;
                n_obsw++;
            end
            if (mem_rd) begin
                if (n_rd < 1024) obs_ra[n_rd] = mem_addr;
                n_rd++;
                if (fetch_k < n_desc && mem_addr == desc_at[fetch_k]) begin
                    if (n_obsw != 4 * fetch_k) ord_bad++;
                    fetch_k++;
                end
            end
            if (irq_pulse) obs_irq++;
        end
    end

    task automatic build_expect(input logic [31:0] p0);
        logic [31:0] p, nx, bf, ct, af, w;
        p = p0; n_exp = 0; n_expw = 0; exp_irq = 0; n_desc = 0;
        for (int k = 0; k < 16; k++) begin
            nx = mem[p[11:2]];
            bf = mem[p[11:2] + 10'd1];
            ct = mem[p[11:2] + 10'd2];
            af = mem[p[11:2] + 10'd3];
            desc_at[n_desc] = p; n_desc++;
            for (logic [31:0] a = bf; a != af; a++) begin
                w = mem[a[11:2]];
                exp_byte[n_exp] = w[int'(a[1:0]) * 8 +: 8];
                exp_last[n_exp] = ct[3] && (a == af - 1);
                n_exp++;
            end
            if (ct[4]) exp_irq++;
            for (int j = 0; j < 4; j++) begin
                exp_wa[n_expw] = p + 32'(4 * j);
                exp_wd[n_expw] = mem[p[11:2] + 10'(j)];
                n_expw++;
            end
            if (ct[0]) break;
            p = nx;
        end
    endtask

    task automatic run_chain(input logic [31:0] p, input bit interfere, input bit chk_restart);
        int w, bad_b, bad_l, bad_w;
        int q_obs, q_w, q_rd;
        build_expect(p);
        n_obs = 0; n_obsw = 0; n_rd = 0; obs_irq = 0; fetch_k = 0; ord_bad = 0;
        @(negedge clk); start = 1'b1; start_ptr = p;
        @(negedge clk); start = 1'b0; start_ptr = 32'h3F0;
        if (chk_restart)
            chk(eol_flag == 1'b0 && busy == 1'b1, "R12", "eol cleared on start",
                {30'd0, eol_flag, busy}, 32'd1);
        w = 0;
        while (busy && w < 4000) begin
            @(negedge clk); w++;
            start = (interfere && w == 5);
        end
        start = 1'b0;
        chk(w < 4000, "R9", "chain completes", w, 4000);
        bad_b = 0; bad_l = 0;
        for (int i = 0; i < n_exp && i < n_obs; i++) begin
            if (obs_byte[i] !== exp_byte[i]) bad_b++;
            if (obs_last[i] !== exp_last[i]) bad_l++;
        end
        chk(n_obs == n_exp, "R3", "byte count", n_obs, n_exp);
        chk(bad_b == 0, "R3", "byte mismatches", bad_b, 0);
        chk(bad_l == 0, "R5", "last marker mismatches", bad_l, 0);
        chk(obs_irq == exp_irq, "R6", "irq pulses", obs_irq, exp_irq);
        chk(n_obsw == n_expw, "R7", "writeback count", n_obsw, n_expw);
        bad_w = 0;
        for (int i = 0; i < n_expw && i < n_obsw; i++)
            if (obs_wa[i] !== exp_wa[i] || obs_wd[i] !== exp_wd[i]) bad_w++;
        chk(bad_w == 0, "R7", "writeback words", bad_w, 0);
        chk(ord_bad == 0, "R7", "writeback before next fetch", ord_bad, 0);
        chk(fetch_k == n_desc, "R8", "descriptors followed", fetch_k, n_desc);
        chk(eol_flag == 1'b1 && busy == 1'b0, "R9", "stopped with eol",
            {30'd0, eol_flag, busy}, 32'd2);
        q_obs = n_obs; q_w = n_obsw; q_rd = n_rd;
        repeat (10) @(negedge clk);
        chk(n_obs == q_obs && n_obsw == q_w && n_rd == q_rd, "R9", "quiet after eol",
            n_obs + n_obsw + n_rd, q_obs + q_w + q_rd);
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] bf,
                            input logic [31:0] ct, input logic [31:0] af);
        mem[a[11:2]]         = nx;
        mem[a[11:2] + 10'd1] = bf;
        mem[a[11:2] + 10'd2] = ct;
        mem[a[11:2] + 10'd3] = af;
    endtask

    initial begin
        logic [31:0] a, bf, ct;
        int nd;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        n_desc = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && eol_flag == 0 && st_valid == 0 && irq_pulse == 0
            && mem_rd == 0 && mem_wr == 0, "R1", "reset outputs",
            {26'd0, busy, eol_flag, st_valid, irq_pulse, mem_rd, mem_wr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && st_valid == 0, "R1", "idle after reset", {30'd0, busy, st_valid}, 0);

        // directed: unaligned single descriptor, eop+intr+end, stray bits 5 and 11 set (R2)
        put_desc(32'h040, 32'h0000_0123, 32'h403, 32'hABCD_0839, 32'h40A);
        run_chain(32'h040, 1'b0, 1'b0);
        chk(obs_ra[0] == 32'h040 && obs_ra[1] == 32'h044 && obs_ra[2] == 32'h048
            && obs_ra[3] == 32'h04C, "R2", "descriptor read order", obs_ra[3], 32'h04C);
        chk(n_obs == 7 && obs_last[6] == 1'b1 && obs_last[0] == 1'b0, "R5",
            "marker on last byte only", n_obs, 7);
        chk(obs_irq == 1, "R6", "one pulse", obs_irq, 1);

        // directed: empty interrupting descriptor then 3-byte end descriptor, start while busy
        put_desc(32'h080, 32'h0C0, 32'h500, 32'h0000_0010, 32'h500);
        put_desc(32'h0C0, 32'h777, 32'h510, 32'h0000_0001, 32'h513);
        rdy_mode = 1;
        run_chain(32'h080, 1'b1, 1'b1);
        chk(n_obs == 3 && obs_irq == 1, "R10", "empty descriptor moves nothing",
            n_obs, 3);
        chk(obs_wa[0] == 32'h080 && obs_wa[4] == 32'h0C0, "R11",
            "start during run ignored", obs_wa[4], 32'h0C0);

        // random chains with random backpressure
        for (int r = 0; r < 30; r++) begin
            nd = 1 + ($urandom % 4);
            for (int k = 0; k < nd; k++) begin
                a  = 32'(((r * 4 + k) % 64) * 16);
                bf = 32'h400 + ($urandom % 32'hB00);
                ct = ($urandom & 32'hFFFF_0838) | ((k == nd - 1) ? 32'h1 : 32'h0);
                put_desc(a, (k < nd - 1) ? 32'(((r * 4 + k + 1) % 64) * 16) : ($urandom & 32'hFFC),
                         bf, ct, bf + ($urandom % 13));
            end
            rdy_mode = r % 2;
            run_chain(32'(((r * 4) % 64) * 16), (r % 3 == 0), (r % 5 == 0));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule